// File: doc/BRIEF.md
# GPIO Interrupt Line Router

This block takes the interrupt requests of three GPIO banks (14, 24 and 32 lines, 70 sources in all) and places them onto 41 interrupt-controller inputs. Of these, 38 are exclusive lines that each carry one source. The other 3 are shared lines, one per bank. Each shared line is the OR of every source in that bank that does not own an exclusive line at the moment.

A single 32-bit configuration register decides who owns each of the 32 reassignable exclusive slots. Slot k offers a choice between two sources. For k below 14 the default is bank 0 line k, and otherwise it is bank 1 line k-14. The alternative is always bank 2 line k. Six further exclusive lines always carry bank 1 lines 18 to 23, whatever the register holds. Software reaches the register through a simple select/write-enable bus at byte offset 0x54. Routing follows the sources without any clock delay. The outputs can also be registered, through a parameter.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset the routing register reads 0. Banks 0 and 1 then have their reassignable lines on exclusive slots, and all of bank 2 drives shared line 2.
- R2: A write with bus_sel=1, bus_we=1 and bus_addr=0x54 loads bus_wdata at the next rising clock edge. A read with bus_sel=1 at 0x54 returns the register value. A write to any other offset leaves the register unchanged, and a read from any other offset returns 0.
- R3: When register bit k is 0, irq_direct[k] carries bank 0 line k (k<14) or bank 1 line k-14 (14≤k≤31).
- R4: When register bit k is 1, irq_direct[k] carries bank 2 line k.
- R5: irq_direct[32+i] carries bank 1 line 18+i for i=0..5, under every register value.
- R6: irq_shared[0] is the OR of the bank 0 lines k whose register bit k is 1.
- R7: irq_shared[1] is the OR of the bank 1 lines j (j≤17) whose register bit 14+j is 1.
- R8: irq_shared[2] is the OR of the bank 2 lines k whose register bit k is 0. It is low whenever all of those lines are low.
- R9: With REG_OUT=0, any single asserted source appears on exactly one of the 41 outputs in the same cycle, and every other output stays low.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write enable (1 = write) |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| src_g0 | input | 14 | Bank 0 interrupt requests |
| src_g1 | input | 24 | Bank 1 interrupt requests |
| src_g2 | input | 32 | Bank 2 interrupt requests |
| irq_direct | output | 38 | Exclusive lines: slots 0..31, then pinned bank 1 lines 18..23 |
| irq_shared | output | 3 | Shared line per bank, index = bank |

## Verification
Each source is raised alone, one at a time, under six register values: all zeros, all ones, the two alternating patterns, and the two half-word masks. A one-hot source thereby shows exactly which output it lands on, so a wrong slot, a swapped bank or a duplicated route reveals itself. Every source is also tried under both values of its own deciding bit. All sources high under both extreme settings shows that the shared ORs collect only the displaced lines. A source dropping on an otherwise idle bank shows that the shared line deasserts. Writes and reads at a wrong offset show that the register decodes only its own address.

// File: rtl/irqmux_pkg.sv
package irqmux_pkg;
  localparam int G0_N     = 14;
  localparam int G1_N     = 24;
  localparam int G2_N     = 32;
  localparam int SLOTS    = G2_N;
  localparam int G1_MUX   = SLOTS - G0_N;
  localparam int PINNED   = G1_N - G1_MUX;
  localparam int DIRECT_N = SLOTS + PINNED;
  localparam int BANKS    = 3;
  localparam int CFG_W    = SLOTS;

  function automatic logic masked_any(input logic [SLOTS-1:0] src,
                                      input logic [SLOTS-1:0] keep);
    return |(src & keep);
  endfunction
endpackage

// File: rtl/irqmux_cfg_reg.sv
module irqmux_cfg_reg #(
  parameter int          ADDR_W = 8,
  parameter int          DATA_W = 32,
  parameter logic [7:0]  OFFSET = 8'h54
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] cfg_q
);
  logic hit;
  assign hit = bus_sel && (bus_addr == ADDR_W'(OFFSET));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cfg_q <= '0;
    else if (hit && bus_we) cfg_q <= bus_wdata;
  end

  assign bus_rdata = (hit && !bus_we) ? cfg_q : '0;
endmodule

// File: rtl/irqmux_slot_sel.sv
module irqmux_slot_sel #(
  parameter int N = 32
) (
  input  logic [N-1:0] base_src,
  input  logic [N-1:0] alt_src,
  input  logic [N-1:0] pick_alt,
  output logic [N-1:0] slot_out
);
  for (genvar k = 0; k < N; k++) begin : g_slot
    assign slot_out[k] = pick_alt[k] ? alt_src[k] : base_src[k];
  end
endmodule

// File: rtl/irqmux_shared_or.sv
module irqmux_shared_or
  import irqmux_pkg::*;
(
  input  logic [G0_N-1:0]   src_g0,
  input  logic [G1_MUX-1:0] src_g1_mux,
  input  logic [G2_N-1:0]   src_g2,
  input  logic [CFG_W-1:0]  cfg,
  output logic [BANKS-1:0]  shared
);
  assign shared[0] = masked_any(SLOTS'(src_g0), SLOTS'(cfg[G0_N-1:0]));
  assign shared[1] = masked_any(SLOTS'(src_g1_mux), SLOTS'(cfg[SLOTS-1:G0_N]));
  assign shared[2] = masked_any(src_g2, ~cfg);
endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
  import irqmux_pkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] OFFSET  = 8'h54,
  parameter bit         REG_OUT = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_we,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [CFG_W-1:0]    bus_wdata,
  output logic [CFG_W-1:0]    bus_rdata,
  input  logic [G0_N-1:0]     src_g0,
  input  logic [G1_N-1:0]     src_g1,
  input  logic [G2_N-1:0]     src_g2,
  output logic [DIRECT_N-1:0] irq_direct,
  output logic [BANKS-1:0]    irq_shared
);
  logic [CFG_W-1:0]    cfg_q;
  logic [SLOTS-1:0]    base_src;
  logic [SLOTS-1:0]    slot_out;
  logic [DIRECT_N-1:0] dir_pre;
  logic [BANKS-1:0]    shr_pre;

  irqmux_cfg_reg #(.ADDR_W(ADDR_W), .DATA_W(CFG_W), .OFFSET(OFFSET)) u_cfg (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg_q(cfg_q)
  );

  assign base_src = {src_g1[G1_MUX-1:0], src_g0};

  irqmux_slot_sel #(.N(SLOTS)) u_slots (
    .base_src(base_src), .alt_src(src_g2), .pick_alt(cfg_q), .slot_out(slot_out)
  );

  irqmux_shared_or u_shared (
    .src_g0(src_g0), .src_g1_mux(src_g1[G1_MUX-1:0]), .src_g2(src_g2),
    .cfg(cfg_q), .shared(shr_pre)
  );

  assign dir_pre = {src_g1[G1_N-1:G1_MUX], slot_out};

  if (REG_OUT) begin : g_reg_out
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        irq_direct <= '0;
        irq_shared <= '0;
      end else begin
        irq_direct <= dir_pre;
        irq_shared <= shr_pre;
      end
    end
  end else begin : g_comb_out
    assign irq_direct = dir_pre;
    assign irq_shared = shr_pre;
  end
endmodule

// File: rtl/irqmux_chk.sv
module irqmux_chk
  import irqmux_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter logic [7:0] OFFSET = 8'h54
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_sel,
  input logic                bus_we,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic [CFG_W-1:0]    bus_wdata,
  input logic [CFG_W-1:0]    cfg_q,
  input logic [G0_N-1:0]     src_g0,
  input logic [G1_N-1:0]     src_g1,
  input logic [G2_N-1:0]     src_g2,
  input logic [DIRECT_N-1:0] dir_pre,
  input logic [BANKS-1:0]    shr_pre
);
  logic wr_hit;
  assign wr_hit = bus_sel && bus_we && (bus_addr == ADDR_W'(OFFSET));

  assert_cfg_reset_R1: assert property (@(posedge clk) !rst_n |=> cfg_q == '0);

  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> cfg_q == $past(bus_wdata));

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(cfg_q));

  for (genvar k = 0; k < SLOTS; k++) begin : g_slot_chk
    assert_slot_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[k] |-> dir_pre[k] == src_g2[k]);
    if (k < G0_N) begin : g_b0
      assert_slot_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[k] |-> dir_pre[k] == src_g0[k]);
    end else begin : g_b1
      assert_slot_base_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[k] |-> dir_pre[k] == src_g1[k-G0_N]);
    end
  end

  assert_pinned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dir_pre[DIRECT_N-1:SLOTS] == src_g1[G1_N-1:G1_MUX]);

  assert_shared0_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(|src_g0) |-> !shr_pre[0]);

  assert_shared1_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|src_g1) |-> !shr_pre[1]);

  assert_shared2_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|src_g2) |-> !shr_pre[2]);

  assert_single_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({src_g0, src_g1, src_g2}) == 1) |->
      ($countones({shr_pre, dir_pre}) == 1));
endmodule

bind gpio_irq_router irqmux_chk #(.ADDR_W(ADDR_W), .OFFSET(OFFSET)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cfg_q(cfg_q),
  .src_g0(src_g0), .src_g1(src_g1), .src_g2(src_g2),
  .dir_pre(dir_pre), .shr_pre(shr_pre)
);

// File: tb/gpio_irq_router_tb.sv
module gpio_irq_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [13:0] src_g0 = '0;
  logic [23:0] src_g1 = '0;
  logic [31:0] src_g2 = '0;
  logic [37:0] irq_direct;
  logic [2:0]  irq_shared;

  int nvec = 0, nerr = 0;
  bit done = 1'b0;

  localparam logic [31:0] CFG_TAB [6] = '{32'h0000_0000, 32'hFFFF_FFFF,
    32'h5555_5555, 32'hAAAA_AAAA, 32'h0000_FFFF, 32'hFFFF_0000};

  always #5 clk = ~clk;

  gpio_irq_router dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_g0(src_g0), .src_g1(src_g1), .src_g2(src_g2),
    .irq_direct(irq_direct), .irq_shared(irq_shared)
  );

  // Output index 0..37 = exclusive lines, 38..40 = shared line of bank 0..2
  function automatic int route_of(int g, int l, logic [31:0] c);
    if (g == 0) return c[l] ? 38 : l;
    if (g == 1) begin
      if (l >= 18) return 32 + (l - 18);
      return c[14 + l] ? 39 : 14 + l;
    end
    return c[l] ? l : 40;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd_check(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #2;
    check(bus_rdata == exp, req, 64'(bus_rdata), 64'(exp));
    bus_sel = 1'b0;
  endtask

  task automatic drive_one(int g, int l);
    src_g0 = '0; src_g1 = '0; src_g2 = '0;
    if (g == 0) src_g0[l] = 1'b1;
    else if (g == 1) src_g1[l] = 1'b1;
    else if (g >= 2) src_g2[l] = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    logic [40:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset value and reset routing
    rd_check(8'h54, 32'h0, "R1 reset value");
    @(negedge clk);
    src_g2 = 32'h0000_0001; #2;
    check({irq_shared, irq_direct} == {3'b100, 38'h0}, "R1 bank2 shared at reset",
          64'({irq_shared, irq_direct}), 64'({3'b100, 38'h0}));
    src_g2 = '0;

    // Table walk: every source under each configuration (R3 R4 R5 R6 R7 R8 R9)
    foreach (CFG_TAB[t]) begin
      wr(8'h54, CFG_TAB[t]);
      rd_check(8'h54, CFG_TAB[t], "R2 readback");
      for (int g = 0; g < 3; g++) begin
        for (int l = 0; l < (g == 0 ? 14 : (g == 1 ? 24 : 32)); l++) begin
          @(negedge clk);
          drive_one(g, l);
          #2;
          exp = 41'(1) << route_of(g, l, CFG_TAB[t]);
          check({irq_shared, irq_direct} == exp,
                "R3/R4/R5/R6/R7/R8 route, R9 single output",
                64'({irq_shared, irq_direct}), 64'(exp));
        end
      end
    end

    // R2: wrong-offset write ignored, wrong-offset read is 0
    wr(8'h54, 32'h1234_5678);
    wr(8'h50, 32'hDEAD_BEEF);
    rd_check(8'h54, 32'h1234_5678, "R2 other offset write ignored");
    rd_check(8'h58, 32'h0, "R2 other offset read zero");

    // R6 R7 R8: all sources high, extreme settings
    wr(8'h54, 32'h0);
    @(negedge clk);
    src_g0 = '1; src_g1 = '1; src_g2 = '1; #2;
    check(irq_shared == 3'b100 && irq_direct == '1, "R8 all high cfg=0",
          64'({irq_shared, irq_direct}), 64'({3'b100, 38'h3F_FFFF_FFFF}));
    wr(8'h54, 32'hFFFF_FFFF);
    #2;
    check(irq_shared == 3'b011 && irq_direct == '1, "R6 R7 all high cfg=ones",
          64'({irq_shared, irq_direct}), 64'({3'b011, 38'h3F_FFFF_FFFF}));

    // R8: shared line deasserts when contributing sources drop
    wr(8'h54, 32'h0000_FFFF);
    @(negedge clk);
    src_g0 = '0; src_g1 = '0; src_g2 = 32'h0003_0000; #2;
    check(irq_shared == 3'b100, "R8 shared high", 64'(irq_shared), 64'(3'b100));
    @(negedge clk);
    src_g2 = 32'h0000_0001; #2;
    check(irq_shared == 3'b000, "R8 shared deasserts", 64'(irq_shared), 64'(3'b000));
    check(irq_direct == 38'h1, "R4 slot0 from bank2", 64'(irq_direct), 64'(38'h1));

    // R5: pinned lines ignore configuration
    @(negedge clk);
    src_g2 = '0; src_g1 = 24'hFC_0000; #2;
    check(irq_direct == {6'h3F, 32'h0} && irq_shared == 3'b000, "R5 pinned",
          64'({irq_shared, irq_direct}), 64'({3'b000, 6'h3F, 32'h0}));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule